// File: doc/BRIEF.md
# Dual-Edge GPIO Interrupt Controller

This block serves a bank of general-purpose pins, sixteen by default. Software picks which pins it drives and the levels they carry. It can read back the pin levels after they have been synchronised. Every pin can report a low-to-high transition, a high-to-low transition, or both. Each kind of transition has its own enable and its own sticky status flag, so a pin can be armed for one direction and masked for the other. A typical case is a presence-detect line that interrupts only when it is pulled low.

The host reaches the block through a plain 16-bit register port. Writes take effect on the clock edge. Reads are combinational from the address. The port shows every register with its two bytes exchanged, the way a big-endian peripheral would present them. A host value `H` therefore lands internally as `{H[7:0], H[15:8]}`, and a read reverses that exchange. A single level-sensitive interrupt output is high while any latched transition has its matching enable set.

Top module: `gpio_edge_irq`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising clock edge), every register reads zero, `pinOe` and `pinOut` are zero and `irqOut` is low.
- R2: The host port exchanges bytes. A host value H written at any register offset is stored as {H[7:0],H[15:8]}, and reading that register returns H again.
- R3: Offset 0x0 holds the direction word and offset 0x2 the output word. `pinOe` equals the stored direction word. `pinOut` carries the output-word bit for pins whose direction bit is 1 and 0 for the others. `pinOe` changes only after a write.
- R4: Offset 0x4 returns the pin levels, byte-exchanged, once they have passed a two-flop synchroniser. A change on `pinIn` made between clock edges is visible after the second following edge. Writes to 0x4 have no effect.
- R5: A 0-to-1 transition of a synchronised pin sets that pin's bit in the rising status word (offset 0xA). A 1-to-0 transition sets its bit in the falling status word (offset 0xC). Both are set whatever the enables hold, and are visible after the third edge following the pin change.
- R6: Status bits are sticky. They stay set until the host clears them.
- R7: Writing a status offset clears each internal bit whose written bit is 1. Bits written as 0 are left unchanged.
- R8: When a transition sets a status bit in the same cycle as a write clearing that bit, the bit ends up set.
- R9: `irqOut` is high exactly when some pin has (rising status AND rising enable) OR (falling status AND falling enable). The rising enable is at offset 0x6 and the falling enable at 0x8. A pin armed only for falling transitions raises no interrupt on a rising one.
- R10: The rising and falling enable words are written and read back independently. Changing one bit of the falling enable word by a full-word write leaves the other bits as written.
- R11: Offsets other than 0x0, 0x2, 0x4, 0x6, 0x8, 0xA and 0xC read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostAddr | input | 4 | Byte offset of the register accessed |
| hostWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| hostWrData | input | 16 | Write value as the host sees it (byte-exchanged) |
| hostRdData | output | 16 | Read value of the addressed register (byte-exchanged) |
| pinIn | input | 16 | Asynchronous pin levels |
| pinOut | output | 16 | Driven pin levels, masked by direction |
| pinOe | output | 16 | Per-pin drive enable |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench drives rising transitions on several pins at once, falling transitions on a single pin, and transitions on a pin armed only for falling edges. These patterns separate the two status words, show that enables mask the interrupt but not the latching, and confirm that the direction of a transition is not mixed up. Register values with unequal bytes show whether the byte exchange is applied on both the write path and the read path. Sampling the input readback one cycle and then two cycles after a change pins down the synchroniser depth. A clear write that lands on the same edge as a new transition shows which of the two wins.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int HOST_ADDR_W = 4;

  localparam logic [HOST_ADDR_W-1:0] OFS_DIR     = 4'h0;
  localparam logic [HOST_ADDR_W-1:0] OFS_DOUT    = 4'h2;
  localparam logic [HOST_ADDR_W-1:0] OFS_DIN     = 4'h4;
  localparam logic [HOST_ADDR_W-1:0] OFS_RISE_EN = 4'h6;
  localparam logic [HOST_ADDR_W-1:0] OFS_FALL_EN = 4'h8;
  localparam logic [HOST_ADDR_W-1:0] OFS_RISE_ST = 4'hA;
  localparam logic [HOST_ADDR_W-1:0] OFS_FALL_ST = 4'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_DOUT,
    SEL_DIN,
    SEL_RISE_EN,
    SEL_FALL_EN,
    SEL_RISE_ST,
    SEL_FALL_ST
  } rdSel_e;

  typedef struct packed {
    logic wrDir;
    logic wrDout;
    logic wrRiseEn;
    logic wrFallEn;
    logic clrRise;
    logic clrFall;
  } ctlStrobe_t;

endpackage

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl
  import gpio_edge_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic [HOST_ADDR_W-1:0] hostAddr,
  input  logic                   hostWrEn,
  input  logic [PIN_W-1:0]       hostWrData,
  output logic [PIN_W-1:0]       hostRdData,
  input  logic [PIN_W-1:0]       rdWord,
  output logic [PIN_W-1:0]       wrWord,
  output rdSel_e                 rdSel,
  output ctlStrobe_t             strb
);

  localparam int NUM_BYTES = PIN_W / 8;

  // byte exchange on both directions of the host port
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_swap
    assign wrWord[8*b +: 8]     = hostWrData[8*(NUM_BYTES-1-b) +: 8];
    assign hostRdData[8*b +: 8] = rdWord[8*(NUM_BYTES-1-b) +: 8];
  end

  always_comb begin
    strb  = '0;
    rdSel = SEL_NONE;
    case (hostAddr)
      OFS_DIR:     begin rdSel = SEL_DIR;     strb.wrDir    = hostWrEn; end
      OFS_DOUT:    begin rdSel = SEL_DOUT;    strb.wrDout   = hostWrEn; end
      OFS_DIN:     begin rdSel = SEL_DIN;                              end
      OFS_RISE_EN: begin rdSel = SEL_RISE_EN; strb.wrRiseEn = hostWrEn; end
      OFS_FALL_EN: begin rdSel = SEL_FALL_EN; strb.wrFallEn = hostWrEn; end
      OFS_RISE_ST: begin rdSel = SEL_RISE_ST; strb.clrRise  = hostWrEn; end
      OFS_FALL_ST: begin rdSel = SEL_FALL_ST; strb.clrFall  = hostWrEn; end
      default:     begin rdSel = SEL_NONE;                             end
    endcase
  end

endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int PIN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobe_t       strb,
  input  rdSel_e           rdSel,
  input  logic [PIN_W-1:0] wrWord,
  output logic [PIN_W-1:0] rdWord,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOe,
  output logic [PIN_W-1:0] riseEn,
  output logic [PIN_W-1:0] fallEn,
  output logic [PIN_W-1:0] riseStat,
  output logic [PIN_W-1:0] fallStat
);

  logic [PIN_W-1:0] dirReg, doutReg;
  logic [PIN_W-1:0] syncQ [SYNC_STAGES];
  logic [PIN_W-1:0] pinLvl, prevLvl, riseEv, fallEv;

  // synchroniser chain
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
    end
  end

  assign pinLvl = syncQ[SYNC_STAGES-1];
  assign riseEv = pinLvl & ~prevLvl;
  assign fallEv = ~pinLvl & prevLvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLvl  <= '0;
      dirReg   <= '0;
      doutReg  <= '0;
      riseEn   <= '0;
      fallEn   <= '0;
      riseStat <= '0;
      fallStat <= '0;
    end else begin
      prevLvl <= pinLvl;
      if (strb.wrDir)    dirReg  <= wrWord;
      if (strb.wrDout)   doutReg <= wrWord;
      if (strb.wrRiseEn) riseEn  <= wrWord;
      if (strb.wrFallEn) fallEn  <= wrWord;
      // a new event outranks a clear of the same bit
      riseStat <= (riseStat & ~(strb.clrRise ? wrWord : '0)) | riseEv;
      fallStat <= (fallStat & ~(strb.clrFall ? wrWord : '0)) | fallEv;
    end
  end

  assign pinOe  = dirReg;
  assign pinOut = doutReg & dirReg;

  always_comb begin
    case (rdSel)
      SEL_DIR:     rdWord = dirReg;
      SEL_DOUT:    rdWord = doutReg;
      SEL_DIN:     rdWord = pinLvl;
      SEL_RISE_EN: rdWord = riseEn;
      SEL_FALL_EN: rdWord = fallEn;
      SEL_RISE_ST: rdWord = riseStat;
      SEL_FALL_ST: rdWord = fallStat;
      default:     rdWord = '0;
    endcase
  end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int PIN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [HOST_ADDR_W-1:0] hostAddr,
  input  logic                   hostWrEn,
  input  logic [PIN_W-1:0]       hostWrData,
  output logic [PIN_W-1:0]       hostRdData,
  input  logic [PIN_W-1:0]       pinIn,
  output logic [PIN_W-1:0]       pinOut,
  output logic [PIN_W-1:0]       pinOe,
  output logic                   irqOut
);

  ctlStrobe_t       strb;
  rdSel_e           rdSel;
  logic [PIN_W-1:0] wrWord, rdWord;
  logic [PIN_W-1:0] riseEn, fallEn, riseStat, fallStat;

  gpio_edge_ctl #(.PIN_W(PIN_W)) u_ctl (
    .hostAddr   (hostAddr),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .rdWord     (rdWord),
    .wrWord     (wrWord),
    .rdSel      (rdSel),
    .strb       (strb)
  );

  gpio_edge_dp #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .rdSel    (rdSel),
    .wrWord   (wrWord),
    .rdWord   (rdWord),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .riseEn   (riseEn),
    .fallEn   (fallEn),
    .riseStat (riseStat),
    .fallStat (fallStat)
  );

  assign irqOut = |((riseStat & riseEn) | (fallStat & fallEn));

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int PIN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             hostWrEn,
  input logic [PIN_W-1:0] pinOe,
  input logic [PIN_W-1:0] riseStat,
  input logic [PIN_W-1:0] fallStat,
  input logic             irqOut
);

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hostWrEn |=> $stable(pinOe)); // R3

  AST_RISE_STICKY: assert property (@(posedge clk) disable iff (rst)
    !hostWrEn |=> ((riseStat & $past(riseStat)) == $past(riseStat))); // R6

  AST_FALL_STICKY: assert property (@(posedge clk) disable iff (rst)
    !hostWrEn |=> ((fallStat & $past(fallStat)) == $past(fallStat))); // R6

  AST_IRQ_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(irqOut) |-> $past(hostWrEn)); // R9

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.PIN_W(PIN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hostWrEn (hostWrEn),
  .pinOe    (pinOe),
  .riseStat (riseStat),
  .fallStat (fallStat),
  .irqOut   (irqOut)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  hostAddr = 4'h0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = 16'h0;
  logic [15:0] hostRdData;
  logic [15:0] pinIn = 16'h0;
  logic [15:0] pinOut, pinOe;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk(clk), .rst(rst), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  function automatic logic [15:0] sw(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // address, write value, expected read-back value (host view)
  localparam logic [47:0] VEC [7] = '{
    {16'h0000, 16'h1234, 16'h1234},  // R2 direction
    {16'h0002, 16'h00FF, 16'h00FF},  // R2 output word
    {16'h0006, 16'hA55A, 16'hA55A},  // R10 rising enable
    {16'h0008, 16'h0100, 16'h0100},  // R10 falling enable
    {16'h0004, 16'hFFFF, 16'h0000},  // R4 input word ignores writes
    {16'h000E, 16'hBEEF, 16'h0000},  // R11 unmapped
    {16'h0001, 16'h7777, 16'h0000}   // R11 odd offset
  };

  initial begin
    logic [15:0] v;
    cyc(3);
    rst = 1'b0;
    cyc(1);

    // R1 reset state
    for (int a = 0; a < 14; a += 2) begin
      rd(4'(a), v);
      chk("R1 register zero", v, 16'h0);
    end
    chk("R1 pinOe", pinOe, 16'h0);
    chk("R1 pinOut", pinOut, 16'h0);
    chk("R1 irqOut", {15'h0, irqOut}, 16'h0);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rd(VEC[i][35:32], v);
      chk("R2/R4/R10/R11 vector", v, VEC[i][15:0]);
    end

    // R3 drive mapping: dir internal 0x3412, dout internal 0xFF00
    chk("R3 pinOe", pinOe, 16'h3412);
    chk("R3 pinOut", pinOut, 16'h3400);
    chk("R2 pinOe byte exchange", pinOe, sw(16'h1234));
    wr(4'h6, 16'h0000);
    wr(4'h8, 16'h0000);

    // R4 synchroniser depth
    pinIn = 16'h0081;
    cyc(1);
    rd(4'h4, v); chk("R4 not yet visible", v, 16'h0000);
    cyc(1);
    rd(4'h4, v); chk("R4 level visible", v, sw(16'h0081));
    cyc(1);
    // R5 rising latched, masked
    rd(4'hA, v); chk("R5 rising status", v, sw(16'h0081));
    rd(4'hC, v); chk("R5 falling status clean", v, 16'h0000);
    chk("R9 masked irq", {15'h0, irqOut}, 16'h0);

    wr(4'h6, sw(16'h0001));
    chk("R9 irq on enabled rise", {15'h0, irqOut}, 16'h1);

    // R7 clear bit0 only
    wr(4'hA, sw(16'h0001));
    rd(4'hA, v); chk("R7 write-one clear", v, sw(16'h0080));
    chk("R7 irq after clear", {15'h0, irqOut}, 16'h0);

    cyc(5);
    rd(4'hA, v); chk("R6 sticky", v, sw(16'h0080));

    // falling on pin 7
    pinIn = 16'h0001;
    cyc(3);
    rd(4'hC, v); chk("R5 falling status", v, sw(16'h0080));
    wr(4'h8, sw(16'h0080));
    chk("R9 irq on enabled fall", {15'h0, irqOut}, 16'h1);

    // falling-only arming of pin 3
    wr(4'h8, sw(16'h0008));
    chk("R9 irq after re-arm", {15'h0, irqOut}, 16'h0);
    pinIn = 16'h0009;
    cyc(3);
    chk("R9 rising ignored on fall-only pin", {15'h0, irqOut}, 16'h0);
    pinIn = 16'h0001;
    cyc(3);
    chk("R9 fall-only pin fires", {15'h0, irqOut}, 16'h1);

    // R10 single-bit change
    wr(4'h8, sw(16'h0028));
    rd(4'h8, v); chk("R10 add bit", v, sw(16'h0028));
    wr(4'h8, sw(16'h0008));
    rd(4'h8, v); chk("R10 drop bit", v, sw(16'h0008));
    rd(4'h6, v); chk("R10 rising enable untouched", v, sw(16'h0001));

    // R8 clear coincides with rise on pin 2
    pinIn = 16'h0005;
    cyc(2);
    wr(4'hA, sw(16'h0004));
    rd(4'hA, v); chk("R8 event beats clear", v, sw(16'h008C));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule